// File: doc/BRIEF.md
# Windowed Outbound Address Translation Table

This block translates local bus addresses on the outbound side of a PCIe bridge. It keeps a small table of windows. Each window has a power-of-two size and a source base in the local address space. It also holds a 64-bit target base and a 32-bit parameter word. The parameter word selects a memory or configuration transaction and carries a reverse-direction flag. For every lookup the block reports one of two results. On a hit it gives the index of the winning window, the translated address and that window's parameter word. On a miss it raises a miss flag and returns the address unchanged.

Software programs the windows through a 32-bit write port. Each entry has five words. The first source word packs an enable bit, an exponent N and the upper bits of a 4 KiB-aligned base. The window then spans 2^(N+1) bytes. Lookups pass through one register stage, so the result appears on the clock after the request. Building packets and handling the AXI protocol happen outside this block.

Top module: `oat_xlate_table`

## Requirements
- R1: Entry k has five words. They sit at byte offsets 0x800 + 0x20*k, plus 0x0 for source-low, 0x4 for source-high, 0x8 for target-low, 0xC for target-high and 0x10 for the parameter word. With the default of 8 entries the table spans 0x800 to 0x8FF. The block ignores writes outside the table, writes to word offsets 0x14 to 0x1C inside an entry, and writes whose address is not a multiple of 4.
- R2: In the source-low word, bit 0 enables the entry and bits 6:1 hold the size code N. Bits 31:12 give address bits 31:12 of the source base, and bits 11:7 have no effect. A disabled entry never hits.
- R3: An address hits an enabled entry when its bits from N+1 up to 63 equal the same bits of the source base. The source base is {source-high, source-low[31:12], 12'h000}, so a window covers 2^(N+1) bytes. When N = 63 every address hits.
- R4: On a hit, the result address takes bits N+1 and up from the target base {target-high, target-low[31:12], 12'h000}. It takes bits N and below from the lookup address. Bits 11:0 of the target-low word have no effect.
- R5: When several entries hit, the entry with the lowest index wins, and res_idx_o reports that index.
- R6: On a miss, res_miss_o is 1, res_hit_o is 0, res_addr_o equals the lookup address, and res_param_o and res_idx_o are 0.
- R7: On a hit, res_param_o carries the winning entry's full parameter word unchanged. This includes bit 22, the reverse-direction flag, and the transaction ID in the low bits (0 for memory, 1 for configuration).
- R8: A request with lk_valid_i high in one cycle gives res_valid_o high in the next cycle. Every other cycle gives res_valid_o low. res_hit_o and res_miss_o are both 0 while res_valid_o is 0.
- R9: Synchronous reset disables and clears all entries and drives res_valid_o low, so every lookup after reset misses.
- R10: A write in the same cycle as a lookup does not change that lookup's result. It applies from the next cycle's lookup on.
- R11: A configuration window with N = 27 (2^28 bytes), target base 0 and parameter ID 1 maps any address inside the window to its offset within the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 12 | Register byte address |
| cfg_wdata_i | input | 32 | Register write data |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_addr_i | input | 64 | Local address to translate |
| res_valid_o | output | 1 | Result valid, one cycle after request |
| res_hit_o | output | 1 | An enabled window matched |
| res_miss_o | output | 1 | No window matched |
| res_idx_o | output | 3 | Index of the winning entry (0 on miss) |
| res_addr_o | output | 64 | Translated address, or the input address on a miss |
| res_param_o | output | 32 | Parameter word of the winning entry (0 on miss) |

## Verification
A wrong bit of stored entry state shows up at the ports on the first lookup that falls in or near the affected window. It appears one clock after that request as a wrong hit or miss, a wrong index, a shifted window edge or wrong upper address bits. A mis-decoded write address changes an entry that should have stayed untouched, so later lookups into that region give unexpected hits. The bench therefore probes window edges, overlapping windows, the all-space exponent and same-cycle write-and-lookup. It compares every result cycle against a behavioural table model.

// File: rtl/oat_pkg.sv
package oat_pkg;

    localparam int ADDR_W     = 64;
    localparam int REG_W      = 32;
    localparam int PAGE_LSB   = 12;
    localparam int SZC_W      = 6;
    localparam int STRIDE_LSB = 5;   // 32-byte spacing between entries

    typedef enum logic [2:0] {
        W_SRC_LO = 3'd0,
        W_SRC_HI = 3'd1,
        W_DST_LO = 3'd2,
        W_DST_HI = 3'd3,
        W_PARAM  = 3'd4
    } oat_word_e;

    typedef struct packed {
        logic                         en;
        logic [SZC_W-1:0]             szc;
        logic [ADDR_W-1:PAGE_LSB]     src_page;
        logic [ADDR_W-1:PAGE_LSB]     dst_page;
        logic [REG_W-1:0]             param;
    } oat_entry_t;

    // Bits that come from the lookup address: positions 0..N
    function automatic logic [ADDR_W-1:0] offset_mask(input logic [SZC_W-1:0] szc);
        logic [ADDR_W-1:0] m;
        for (int i = 0; i < ADDR_W; i++) begin
            m[i] = (i <= int'(szc));
        end
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:PAGE_LSB] p);
        return {p, {PAGE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/oat_regdec.sv
module oat_regdec
    import oat_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int CFG_AW      = 12,
    parameter int TABLE_BASE  = 'h800
) (
    input  logic                   cfg_we_i,
    input  logic [CFG_AW-1:0]      cfg_addr_i,
    output logic [NUM_ENTRIES-1:0] ent_we_o,
    output oat_word_e              word_o
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int SPAN  = NUM_ENTRIES << STRIDE_LSB;

    logic [CFG_AW-1:0] rel;
    logic              in_tbl;
    logic              word_ok;
    logic [2:0]        word_idx;
    logic [IDX_W-1:0]  sel;

    always_comb begin
        rel      = cfg_addr_i - CFG_AW'(TABLE_BASE);
        in_tbl   = (cfg_addr_i >= CFG_AW'(TABLE_BASE)) && (32'(rel) < 32'(SPAN));
        word_idx = rel[STRIDE_LSB-1:2];
        word_ok  = (rel[1:0] == 2'b00) && (word_idx <= 3'd4);
        sel      = rel[STRIDE_LSB +: IDX_W];
        word_o   = oat_word_e'(word_idx);
        ent_we_o = '0;
        if (cfg_we_i && in_tbl && word_ok) begin
            ent_we_o[sel] = 1'b1;
        end
    end
endmodule

// File: rtl/oat_entry.sv
module oat_entry
    import oat_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  oat_word_e         wr_word_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] xaddr_o,
    output logic [REG_W-1:0]  param_o
);
    oat_entry_t        ent;
    logic [ADDR_W-1:0] keep;
    logic              unused_rsvd;

    assign unused_rsvd = ^wr_data_i[PAGE_LSB-1:SZC_W+1];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ent <= '0;
        end else if (wr_en_i) begin
            case (wr_word_i)
                W_SRC_LO: begin
                    ent.en                         <= wr_data_i[0];
                    ent.szc                        <= wr_data_i[SZC_W:1];
                    ent.src_page[REG_W-1:PAGE_LSB] <= wr_data_i[REG_W-1:PAGE_LSB];
                end
                W_SRC_HI: ent.src_page[ADDR_W-1:REG_W] <= wr_data_i;
                W_DST_LO: ent.dst_page[REG_W-1:PAGE_LSB] <= wr_data_i[REG_W-1:PAGE_LSB];
                W_DST_HI: ent.dst_page[ADDR_W-1:REG_W] <= wr_data_i;
                W_PARAM:  ent.param <= wr_data_i;
                default:  ;
            endcase
        end
    end

    always_comb begin
        keep    = offset_mask(ent.szc);
        hit_o   = ent.en && (((lk_addr_i ^ page_addr(ent.src_page)) & ~keep) == '0);
        xaddr_o = (page_addr(ent.dst_page) & ~keep) | (lk_addr_i & keep);
        param_o = ent.param;
    end
endmodule

// File: rtl/oat_pick.sv
module oat_pick
    import oat_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0]             hit_i,
    input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] xaddr_i,
    input  logic [NUM_ENTRIES-1:0][REG_W-1:0]  param_i,
    output logic [NUM_ENTRIES-1:0]             grant_o,
    output logic                               any_o,
    output logic [IDX_W-1:0]                   idx_o,
    output logic [ADDR_W-1:0]                  addr_o,
    output logic [REG_W-1:0]                   param_o
);
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        idx_o   = '0;
        addr_o  = '0;
        param_o = '0;
        // walk downwards so the lowest hitting index is assigned last
        for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
            if (hit_i[k]) begin
                grant_o    = '0;
                grant_o[k] = 1'b1;
                any_o      = 1'b1;
                idx_o      = IDX_W'(k);
                addr_o     = xaddr_i[k];
                param_o    = param_i[k];
            end
        end
    end
endmodule

// File: rtl/oat_xlate_table.sv
module oat_xlate_table
    import oat_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int CFG_AW      = 12,
    parameter int TABLE_BASE  = 'h800,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cfg_we_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    input  logic              lk_valid_i,
    input  logic [ADDR_W-1:0] lk_addr_i,
    output logic              res_valid_o,
    output logic              res_hit_o,
    output logic              res_miss_o,
    output logic [IDX_W-1:0]  res_idx_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [REG_W-1:0]  res_param_o
);
    logic [NUM_ENTRIES-1:0]             ent_we;
    oat_word_e                          wr_word;
    logic [NUM_ENTRIES-1:0]             ent_hit;
    logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_xaddr;
    logic [NUM_ENTRIES-1:0][REG_W-1:0]  ent_param;
    logic [NUM_ENTRIES-1:0]             pick_grant;
    logic                               pick_any;
    logic [IDX_W-1:0]                   pick_idx;
    logic [ADDR_W-1:0]                  pick_addr;
    logic [REG_W-1:0]                   pick_param;

    logic              valid_q;
    logic              hit_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  param_q;

    oat_regdec #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .CFG_AW      (CFG_AW),
        .TABLE_BASE  (TABLE_BASE)
    ) dec_i (
        .cfg_we_i   (cfg_we_i),
        .cfg_addr_i (cfg_addr_i),
        .ent_we_o   (ent_we),
        .word_o     (wr_word)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        oat_entry ent_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .wr_en_i   (ent_we[g]),
            .wr_word_i (wr_word),
            .wr_data_i (cfg_wdata_i),
            .lk_addr_i (lk_addr_i),
            .hit_o     (ent_hit[g]),
            .xaddr_o   (ent_xaddr[g]),
            .param_o   (ent_param[g])
        );
    end

    oat_pick #(.NUM_ENTRIES(NUM_ENTRIES)) pick_i (
        .hit_i   (ent_hit),
        .xaddr_i (ent_xaddr),
        .param_i (ent_param),
        .grant_o (pick_grant),
        .any_o   (pick_any),
        .idx_o   (pick_idx),
        .addr_o  (pick_addr),
        .param_o (pick_param)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q <= 1'b0;
            hit_q   <= 1'b0;
            idx_q   <= '0;
            addr_q  <= '0;
            param_q <= '0;
        end else begin
            valid_q <= lk_valid_i;
            if (lk_valid_i) begin
                hit_q   <= pick_any;
                idx_q   <= pick_idx;
                addr_q  <= pick_any ? pick_addr : lk_addr_i;
                param_q <= pick_param;
            end
        end
    end

    assign res_valid_o = valid_q;
    assign res_hit_o   = valid_q & hit_q;
    assign res_miss_o  = valid_q & ~hit_q;
    assign res_idx_o   = idx_q;
    assign res_addr_o  = addr_q;
    assign res_param_o = param_q;
endmodule

// File: rtl/oat_chk.sv
module oat_chk
    import oat_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   lk_valid_i,
    input logic [ADDR_W-1:0]      lk_addr_i,
    input logic                   res_valid_o,
    input logic                   res_hit_o,
    input logic                   res_miss_o,
    input logic [IDX_W-1:0]       res_idx_o,
    input logic [ADDR_W-1:0]      res_addr_o,
    input logic [REG_W-1:0]       res_param_o,
    input logic [NUM_ENTRIES-1:0] pick_grant
);
    // R8
    req_to_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lk_valid_i |=> res_valid_o);

    // R8
    no_request_no_result_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !lk_valid_i |=> !res_valid_o);

    // R6
    hit_xor_miss_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o |-> (res_hit_o != res_miss_o));

    // R6
    miss_passthrough_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (res_valid_o && res_miss_o) |->
            (res_addr_o == $past(lk_addr_i) && res_param_o == '0 && res_idx_o == '0));

    // R5
    single_winner_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(pick_grant));

    // R4
    byte_offset_kept_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        res_valid_o |-> (res_addr_o[0] == $past(lk_addr_i[0])));

    // R9
    quiet_after_reset_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !res_valid_o);
endmodule

bind oat_xlate_table oat_chk #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .lk_valid_i  (lk_valid_i),
    .lk_addr_i   (lk_addr_i),
    .res_valid_o (res_valid_o),
    .res_hit_o   (res_hit_o),
    .res_miss_o  (res_miss_o),
    .res_idx_o   (res_idx_o),
    .res_addr_o  (res_addr_o),
    .res_param_o (res_param_o),
    .pick_grant  (pick_grant)
);

// File: tb/oat_xlate_table_tb_top.sv
module oat_xlate_table_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid, res_hit, res_miss;
    logic [2:0]  res_idx;
    logic [63:0] res_addr;
    logic [31:0] res_param;

    always #4 clk = ~clk;  // 125 MHz

    oat_xlate_table dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .cfg_we_i    (cfg_we),
        .cfg_addr_i  (cfg_addr),
        .cfg_wdata_i (cfg_wdata),
        .lk_valid_i  (lk_valid),
        .lk_addr_i   (lk_addr),
        .res_valid_o (res_valid),
        .res_hit_o   (res_hit),
        .res_miss_o  (res_miss),
        .res_idx_o   (res_idx),
        .res_addr_o  (res_addr),
        .res_param_o (res_param)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;
    string tag_now = "R9";
    string tag_q   = "R9";

    // behavioural table model
    logic [31:0] m_slo [8];
    logic [31:0] m_shi [8];
    logic [31:0] m_dlo [8];
    logic [31:0] m_dhi [8];
    logic [31:0] m_par [8];

    logic        exp_valid, exp_hit;
    logic [2:0]  exp_idx;
    logic [63:0] exp_addr;
    logic [31:0] exp_par;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 8; k++) begin
            m_slo[k] = '0; m_shi[k] = '0; m_dlo[k] = '0; m_dhi[k] = '0; m_par[k] = '0;
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        int k, w;
        if (a >= 12'h800 && a < 12'h900 && a[1:0] == 2'b00) begin
            k = (int'(a) - 'h800) / 32;
            w = (int'(a) % 32) / 4;
            case (w)
                0: m_slo[k] = d;
                1: m_shi[k] = d;
                2: m_dlo[k] = d;
                3: m_dhi[k] = d;
                4: m_par[k] = d;
                default: ;
            endcase
        end
    endtask

    task automatic model_lookup(input logic [63:0] a);
        logic [63:0] base, tgt, low;
        int sh;
        bit match;
        exp_hit = 0; exp_idx = '0; exp_addr = a; exp_par = '0;
        for (int k = 0; k < 8; k++) begin
            if (!exp_hit && m_slo[k][0]) begin
                sh    = int'(m_slo[k][6:1]) + 1;
                base  = {m_shi[k], m_slo[k][31:12], 12'h000};
                tgt   = {m_dhi[k], m_dlo[k][31:12], 12'h000};
                match = (sh >= 64) ? 1'b1 : ((a >> sh) == (base >> sh));
                if (match) begin
                    exp_hit = 1;
                    exp_idx = 3'(k);
                    exp_par = m_par[k];
                    if (sh >= 64) exp_addr = a;
                    else begin
                        low      = (64'd1 << sh) - 64'd1;
                        exp_addr = ((tgt >> sh) << sh) | (a & low);
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            exp_valid = 0;
            model_clear();
        end else begin
            exp_valid = lk_valid;
            if (lk_valid) model_lookup(lk_addr);   // R10: lookup sees old table
            if (cfg_we) model_write(cfg_addr, cfg_wdata);
        end
        tag_q = tag_now;
    end

    always @(negedge clk) begin
        if (started) begin
            check(res_valid === exp_valid, {tag_q, "/R8"}, "res_valid", 64'(res_valid), 64'(exp_valid));
            if (exp_valid) begin
                check(res_hit === exp_hit, tag_q, "res_hit", 64'(res_hit), 64'(exp_hit));
                check(res_miss === !exp_hit, {tag_q, "/R6"}, "res_miss", 64'(res_miss), 64'(!exp_hit));
                check(res_idx === exp_idx, {tag_q, "/R5"}, "res_idx", 64'(res_idx), 64'(exp_idx));
                check(res_addr === exp_addr, {tag_q, "/R4"}, "res_addr", res_addr, exp_addr);
                check(res_param === exp_par, {tag_q, "/R7"}, "res_param", 64'(res_param), 64'(exp_par));
            end else begin
                check(res_hit === 1'b0 && res_miss === 1'b0, {tag_q, "/R8"}, "hit|miss idle",
                      64'({res_hit, res_miss}), 64'd0);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            errors++;
            $display("FAIL R8 watchdog actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [11:0] ea(input int k, input int w);
        return 12'('h800 + k * 32 + w * 4);
    endfunction

    task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                        input bit lv, input logic [63:0] la);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; lk_valid = lv; lk_addr = la;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 64'd0);
    endtask

    task automatic lk(input logic [63:0] a);
        step(1'b0, 12'd0, 32'd0, 1'b1, a);
    endtask

    logic [63:0] cand [8];

    initial begin
        // R9: reset state and lookups right after reset
        tag_now = "R9";
        repeat (4) step(1'b0, 12'd0, 32'd0, 1'b0, 64'd0);
        @(negedge clk); rst = 1'b0;
        lk(64'h0); lk(64'h3000_0000); lk(64'hFFFF_FFFF_FFFF_FFFF);

        // R11: configuration window of 2^28 bytes to target 0, ID 1
        tag_now = "R11";
        wr(ea(0, 1), 32'h0000_0009);
        wr(ea(0, 0), 32'h4000_0000 | (27 << 1) | 1);
        wr(ea(0, 2), 32'h0);
        wr(ea(0, 3), 32'h0);
        wr(ea(0, 4), 32'h1);
        lk(64'h9_4123_4567); lk(64'h9_4FFF_FFFF); lk(64'h9_5000_0000); lk(64'h9_3FFF_FFFF);

        // R4 / R7: 1 MiB window, ignored target low bits, reverse flag
        tag_now = "R4";
        wr(ea(3, 0), 32'h3000_0000 | (19 << 1) | 1);
        wr(ea(3, 2), 32'h8765_4FFF);
        wr(ea(3, 3), 32'h0000_0012);
        wr(ea(3, 4), 32'h0040_0000);
        lk(64'h3004_5678);
        tag_now = "R3";
        lk(64'h3000_0000); lk(64'h300F_FFFF); lk(64'h3010_0000); lk(64'h2FFF_FFFF);
        lk(64'h1_3000_0000);

        // R5: overlapping smaller window in lower entry wins
        tag_now = "R5";
        wr(ea(1, 0), 32'h3000_0000 | (11 << 1) | 1);
        wr(ea(1, 2), 32'hA000_0000);
        wr(ea(1, 4), 32'h0000_0000);
        lk(64'h3000_0123); lk(64'h3000_0FFF); lk(64'h3000_1000);

        // R2: disabled entry and reserved bits
        tag_now = "R2";
        wr(ea(2, 0), 32'h5000_0000 | (15 << 1));
        wr(ea(2, 2), 32'hB000_0000);
        lk(64'h5000_0010);
        wr(ea(5, 0), 32'h6000_0000 | (5'h1F << 7) | (13 << 1) | 1);
        wr(ea(5, 4), 32'h0000_0001);
        lk(64'h6000_3FFF); lk(64'h6000_4000);

        // R1: writes outside the table or to unused/unaligned words are ignored
        tag_now = "R1";
        wr(12'h900, 32'h7000_0001);
        wr(12'h7E0, 32'h7000_0001);
        wr(ea(4, 5), 32'h7000_0001);
        wr(ea(4, 7), 32'h7000_0001);
        wr(ea(4, 0) + 12'd2, 32'h7000_0001);
        lk(64'h7000_0000); lk(64'h7000_0001);
        wr(ea(7, 0), 32'h0000_007F);        // R3 edge: N = 63 covers everything
        wr(ea(7, 4), 32'h0000_0005);
        lk(64'h7000_0000); lk(64'hFFFF_0000_1234_5678);

        // R10: disable entry 3 in the same cycle as a lookup into it
        tag_now = "R10";
        step(1'b1, ea(3, 0), 32'h3000_0000 | (19 << 1), 1'b1, 64'h3000_2000);
        lk(64'h3000_2000);

        // R8: random traffic with gaps and occasional table writes
        tag_now = "R8";
        cand[0] = 64'h9_4000_0000; cand[1] = 64'h3000_0000; cand[2] = 64'h5000_0000;
        cand[3] = 64'h6000_0000;   cand[4] = 64'h7000_0000; cand[5] = 64'h0;
        cand[6] = 64'h1_0000_0000; cand[7] = 64'hFFFF_FFFF_F000_0000;
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] a;
            a = cand[$urandom_range(0, 7)] + 64'($urandom_range(0, 32'h0020_0000));
            if ($urandom_range(0, 15) == 0)
                step(1'b1, 12'($urandom_range('h7C0, 'h93F)),
                     $urandom() & 32'hFFFF_FF3F, $urandom_range(0, 1) == 1, a);
            else
                step(1'b0, 12'd0, 32'd0, $urandom_range(0, 3) != 0, a);
        end

        step(1'b0, 12'd0, 32'd0, 1'b0, 64'd0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule